// File: doc/BRIEF.md
# Buffered Asynchronous Serial Transmitter

This block sends bytes, or 9-bit words, over a single NRZ serial line. Each frame has a low start bit, the data bits least significant first, and a high stop bit. A one-entry holding buffer sits in front of the transmit shift register. Software-side logic can therefore queue the next word while the current frame is still going out. The buffered word moves into the shift register at the instant the previous stop bit ends, so consecutive frames follow each other with no idle gap.

The bit rate comes from an internal free-running 8-bit period timer. It produces one tick every `period_val + 1` clocks. A prescaler then divides those ticks by 16 or by 64, as chosen by `div64_sel`. The optional ninth data bit is an ordinary data bit supplied with the write. It can carry software parity or an address marker. The transmitter enable parks the line high and discards all queued or in-flight data.

Top module: `nrz_tx_buffered`

## Requirements
- R1: A frame is a start bit of 0, then data bits wr_data[0] first through wr_data[7], then a stop bit of 1. In 8-bit mode the frame is 10 bits long.
- R2: When nine_bit_en is 1 at the write, wr_data[8] is sent as a ninth data bit straight after wr_data[7], giving an 11-bit frame.
- R3: Every bit lasts exactly (period_val+1)*16 clocks when div64_sel is 0, and (period_val+1)*64 clocks when div64_sel is 1.
- R4: A write accepted into an empty buffer makes hold_empty 0 after that clock edge. With the shift register idle, the start bit appears and hold_empty returns to 1 after the next edge, when shreg_empty also becomes 0.
- R5: A write strobe while the buffer is full is ignored: the buffered word is kept, and the ignored word is never sent.
- R6: A word waiting in the buffer is loaded at the clock edge that ends the previous stop bit. Its start bit follows the stop bit with no idle gap, and hold_empty becomes 1 at that load.
- R7: After reset, and whenever no frame is in progress, serial_out is 1 and shreg_empty is 1. After reset hold_empty is 1.
- R8: While tx_en is 0, serial_out is 1, any frame in progress and any buffered word are discarded, and writes are ignored.
- R9: nine_bit_en is captured together with the data at the write. Changing nine_bit_en or wr_data afterwards does not alter that word's frame.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tx_en | input | 1 | Transmitter enable; 0 idles the line and flushes state |
| nine_bit_en | input | 1 | Selects 9-bit data frames, captured at the write |
| div64_sel | input | 1 | 0: bit = 16 timer ticks, 1: bit = 64 timer ticks |
| period_val | input | 8 | Period timer reload value; tick every period_val+1 clocks |
| wr_stb | input | 1 | Write strobe into the holding buffer |
| wr_data | input | 9 | Word to send; bit 8 is the optional ninth bit |
| serial_out | output | 1 | NRZ serial line, idle high |
| hold_empty | output | 1 | Holding buffer can accept a write |
| shreg_empty | output | 1 | No frame is being shifted out |

## Verification
The assertions assume that reset is held for at least one clock edge. They also assume that `period_val` and `div64_sel` stay constant while a frame is in flight, because the bit length is only defined for a steady rate setting. The stimulus changes these two inputs only while `shreg_empty` is 1. It raises `wr_stb` for single clock cycles only, except where a held strobe is the point of the test. The randomized part draws data, the ninth bit and small period values, so that frames at both prescale settings stay short enough to observe completely.

// File: rtl/txb_pkg.sv
package txb_pkg;

   localparam int unsigned TXB_DEF_DATA_W = 8;
   localparam int unsigned TXB_DEF_TMR_W  = 8;
   localparam int unsigned TXB_DEF_PRE_LO = 16;
   localparam int unsigned TXB_DEF_PRE_HI = 64;

   // number of line bits in a frame: start + data + optional ninth + stop
   function automatic int unsigned txb_frame_bits(input int unsigned data_w, input logic nine);
      return data_w + 2 + (nine ? 1 : 0);
   endfunction

endpackage

// File: rtl/txb_period_timer.sv
module txb_period_timer #(
   parameter int unsigned TMR_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic [TMR_W-1:0] limit,
   output logic             tick
);

   logic [TMR_W-1:0] cnt_q;

   // >= keeps the timer from running past a lowered limit
   assign tick = run && (cnt_q >= limit);

   always_ff @(posedge clk) begin
      if (!rst_n || !run) begin
         cnt_q <= '0;
      end else if (tick) begin
         cnt_q <= '0;
      end else begin
         cnt_q <= cnt_q + 1'b1;
      end
   end

endmodule

// File: rtl/txb_prescaler.sv
module txb_prescaler #(
   parameter int unsigned PRE_LO = 16,
   parameter int unsigned PRE_HI = 64
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   input  logic tick,
   input  logic sel_hi,
   output logic bit_stb
);

   localparam int unsigned PRE_W = (PRE_HI > 1) ? $clog2(PRE_HI) : 1;

   logic [PRE_W-1:0] pc_q;
   logic [PRE_W-1:0] last_val;

   generate
      if (PRE_LO == PRE_HI) begin : g_single
         assign last_val = PRE_W'(PRE_HI - 1);
      end else begin : g_dual
         assign last_val = sel_hi ? PRE_W'(PRE_HI - 1) : PRE_W'(PRE_LO - 1);
      end
   endgenerate

   assign bit_stb = run && tick && (pc_q >= last_val);

   always_ff @(posedge clk) begin
      if (!rst_n || !run) begin
         pc_q <= '0;
      end else if (tick) begin
         if (pc_q >= last_val) begin
            pc_q <= '0;
         end else begin
            pc_q <= pc_q + 1'b1;
         end
      end
   end

endmodule

// File: rtl/txb_hold_buf.sv
module txb_hold_buf #(
   parameter int unsigned W = 10
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         en,
   input  logic         wr,
   input  logic [W-1:0] wdata,
   input  logic         take,
   output logic         full,
   output logic [W-1:0] rdata
);

   logic         full_q;
   logic [W-1:0] word_q;
   logic         accept;

   assign accept = en && wr && !full_q;
   assign full   = full_q;
   assign rdata  = word_q;

   always_ff @(posedge clk) begin
      if (!rst_n || !en) begin
         full_q <= 1'b0;
      end else if (accept) begin
         full_q <= 1'b1;
      end else if (take) begin
         full_q <= 1'b0;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         word_q <= '0;
      end else if (accept) begin
         word_q <= wdata;
      end
   end

endmodule

// File: rtl/txb_shifter.sv
module txb_shifter #(
   parameter int unsigned DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              en,
   input  logic              hold_full,
   input  logic              hold_nine,
   input  logic              hold_ext,
   input  logic [DATA_W-1:0] hold_data,
   input  logic              bit_stb,
   output logic              take,
   output logic              busy,
   output logic              line
);

   localparam int unsigned FRAME_W = DATA_W + 3;
   localparam int unsigned CNT_W   = $clog2(FRAME_W + 1);

   logic               busy_q;
   logic [FRAME_W-1:0] frame_q;
   logic [CNT_W-1:0]   left_q;
   logic               last_bit_end;

   assign last_bit_end = busy_q && bit_stb && (left_q == CNT_W'(1));
   // load from idle, or right at the end of a stop bit
   assign take = en && hold_full && (!busy_q || last_bit_end);
   assign busy = busy_q;
   assign line = !en || !busy_q || frame_q[0];

   always_ff @(posedge clk) begin
      if (!rst_n || !en) begin
         busy_q  <= 1'b0;
         left_q  <= '0;
         frame_q <= '1;
      end else if (take) begin
         busy_q <= 1'b1;
         // a 9-bit slot of 1 in 8-bit mode just lengthens nothing: left_q stops first
         frame_q <= {1'b1, (hold_nine ? hold_ext : 1'b1), hold_data, 1'b0};
         left_q  <= CNT_W'(txb_pkg::txb_frame_bits(DATA_W, hold_nine));
      end else if (busy_q && bit_stb) begin
         frame_q <= {1'b1, frame_q[FRAME_W-1:1]};
         left_q  <= left_q - 1'b1;
         if (left_q == CNT_W'(1)) begin
            busy_q <= 1'b0;
         end
      end
   end

endmodule

// File: rtl/nrz_tx_buffered.sv
module nrz_tx_buffered #(
   parameter int unsigned DATA_W = txb_pkg::TXB_DEF_DATA_W,
   parameter int unsigned TMR_W  = txb_pkg::TXB_DEF_TMR_W,
   parameter int unsigned PRE_LO = txb_pkg::TXB_DEF_PRE_LO,
   parameter int unsigned PRE_HI = txb_pkg::TXB_DEF_PRE_HI
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tx_en,
   input  logic              nine_bit_en,
   input  logic              div64_sel,
   input  logic [TMR_W-1:0]  period_val,
   input  logic              wr_stb,
   input  logic [DATA_W:0]   wr_data,
   output logic              serial_out,
   output logic              hold_empty,
   output logic              shreg_empty
);

   localparam int unsigned HOLD_W = DATA_W + 2;

   generate
      if (DATA_W < 1) begin : g_bad_data
         $error("nrz_tx_buffered: DATA_W must be at least 1");
      end
      if (TMR_W < 1) begin : g_bad_tmr
         $error("nrz_tx_buffered: TMR_W must be at least 1");
      end
      if (PRE_LO < 1 || PRE_HI < PRE_LO) begin : g_bad_pre
         $error("nrz_tx_buffered: need 1 <= PRE_LO <= PRE_HI");
      end
   endgenerate

   logic              tick;
   logic              bit_stb;
   logic              take;
   logic              busy;
   logic              hold_full;
   logic [HOLD_W-1:0] hold_word;
   logic              run;

   assign run = tx_en && busy;

   txb_period_timer #(.TMR_W(TMR_W)) u_timer (
      .clk   (clk),
      .rst_n (rst_n),
      .run   (run),
      .limit (period_val),
      .tick  (tick)
   );

   txb_prescaler #(.PRE_LO(PRE_LO), .PRE_HI(PRE_HI)) u_pre (
      .clk     (clk),
      .rst_n   (rst_n),
      .run     (run),
      .tick    (tick),
      .sel_hi  (div64_sel),
      .bit_stb (bit_stb)
   );

   txb_hold_buf #(.W(HOLD_W)) u_hold (
      .clk   (clk),
      .rst_n (rst_n),
      .en    (tx_en),
      .wr    (wr_stb),
      .wdata ({nine_bit_en, wr_data}),
      .take  (take),
      .full  (hold_full),
      .rdata (hold_word)
   );

   txb_shifter #(.DATA_W(DATA_W)) u_shift (
      .clk       (clk),
      .rst_n     (rst_n),
      .en        (tx_en),
      .hold_full (hold_full),
      .hold_nine (hold_word[HOLD_W-1]),
      .hold_ext  (hold_word[DATA_W]),
      .hold_data (hold_word[DATA_W-1:0]),
      .bit_stb   (bit_stb),
      .take      (take),
      .busy      (busy),
      .line      (serial_out)
   );

   assign hold_empty  = !hold_full;
   assign shreg_empty = !busy;

endmodule

// File: rtl/txb_checker.sv
module txb_checker (
   input logic clk,
   input logic rst_n,
   input logic tx_en,
   input logic wr_stb,
   input logic serial_out,
   input logic hold_empty,
   input logic shreg_empty
);

   // R7: nothing in the shifter means a high line
   p_idle_high_r7: assert property (@(posedge clk) disable iff (!rst_n)
      shreg_empty |-> serial_out);

   // R8: a disabled transmitter parks the line high
   p_disable_high_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !tx_en |-> serial_out);

   // R4: a write into an empty buffer fills it
   p_accept_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_en && wr_stb && hold_empty) |=> !hold_empty);

   // R1, R4: a frame opens with the start bit
   p_start_low_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_en && $fell(shreg_empty)) |-> !serial_out);

   // R6: a load always drains the buffer
   p_load_drains_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_en && $fell(shreg_empty)) |-> hold_empty);

   // R1: a frame that finishes normally ended on a high stop bit
   p_stop_high_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_en && $past(tx_en) && $rose(shreg_empty)) |-> $past(serial_out));

endmodule

bind nrz_tx_buffered txb_checker u_txb_checker (
   .clk         (clk),
   .rst_n       (rst_n),
   .tx_en       (tx_en),
   .wr_stb      (wr_stb),
   .serial_out  (serial_out),
   .hold_empty  (hold_empty),
   .shreg_empty (shreg_empty)
);

// File: tb/tb_nrz_tx_buffered.sv
module tb_nrz_tx_buffered;

   localparam int CLK_PERIOD = 10;
   localparam int WATCHDOG   = 150000;

   logic       clk = 1'b0;
   logic       rst_n;
   logic       tx_en;
   logic       nine_bit_en;
   logic       div64_sel;
   logic [7:0] period_val;
   logic       wr_stb;
   logic [8:0] wr_data;
   logic       serial_out;
   logic       hold_empty;
   logic       shreg_empty;

   int checks = 0;
   int errors = 0;
   bit done   = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   nrz_tx_buffered dut (
      .clk         (clk),
      .rst_n       (rst_n),
      .tx_en       (tx_en),
      .nine_bit_en (nine_bit_en),
      .div64_sel   (div64_sel),
      .period_val  (period_val),
      .wr_stb      (wr_stb),
      .wr_data     (wr_data),
      .serial_out  (serial_out),
      .hold_empty  (hold_empty),
      .shreg_empty (shreg_empty)
   );

   function automatic logic exp_bit(input logic [8:0] d, input logic nine, input int i);
      if (i == 0) return 1'b0;
      if (i <= 8) return d[i-1];
      if (nine && i == 9) return d[8];
      return 1'b1;
   endfunction

   function automatic int exp_len(input logic [7:0] p, input logic sel);
      return (int'(p) + 1) * (sel ? 64 : 16);
   endfunction

   task automatic chk(input logic ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
      end
   endtask

   // called at the negedge where the start bit is first visible;
   // returns at the negedge one frame length later
   task automatic rx_frame(input logic [8:0] d, input logic nine, input int blen, input string tag);
      int nb;
      nb = nine ? 11 : 10;
      for (int i = 0; i < nb; i++) begin
         for (int c = 0; c < blen; c++) begin
            if (c == 0 || c == blen - 1 || c == blen / 2)
               chk(serial_out == exp_bit(d, nine, i), tag, serial_out, exp_bit(d, nine, i));
            @(negedge clk);
         end
      end
   endtask

   // write into an empty, idle transmitter; ends where the start bit shows
   task automatic launch(input logic [8:0] d, input logic nine);
      wr_data     = d;
      nine_bit_en = nine;
      wr_stb      = 1'b1;
      @(negedge clk);
      wr_stb = 1'b0;
      chk(hold_empty == 1'b0, "R4 buffer fills", hold_empty, 0);
      chk(shreg_empty == 1'b1, "R4 shifter idle before load", shreg_empty, 1);
      @(negedge clk);
      chk(hold_empty == 1'b1, "R4 buffer drained at load", hold_empty, 1);
      chk(shreg_empty == 1'b0, "R4 shifter busy after load", shreg_empty, 0);
   endtask

   task automatic idle_check(input string tag);
      chk(serial_out == 1'b1, tag, serial_out, 1);
      chk(shreg_empty == 1'b1, tag, shreg_empty, 1);
   endtask

   initial begin : watchdog
      for (int n = 0; n < WATCHDOG; n++) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog expired actual=%0d expected=%0d", WATCHDOG, 0);
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin : main
      logic [8:0] d;
      logic       nine;
      int         blen;

      void'($urandom(32'd4242));
      rst_n = 1'b0; tx_en = 1'b0; nine_bit_en = 1'b0; div64_sel = 1'b0;
      period_val = 8'd0; wr_stb = 1'b0; wr_data = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      tx_en = 1'b1;
      @(negedge clk);

      // R7 reset state
      idle_check("R7 reset idle");
      chk(hold_empty == 1'b1, "R7 reset buffer empty", hold_empty, 1);

      // R1 R3 8-bit, period 0, x16
      period_val = 8'd0; div64_sel = 1'b0;
      launch(9'h0A5, 1'b0);
      rx_frame(9'h0A5, 1'b0, exp_len(8'd0, 1'b0), "R1 R3 8-bit x16 p0");
      idle_check("R7 idle after frame");

      // R2 R3 9-bit, x64
      period_val = 8'd1; div64_sel = 1'b1;
      launch(9'h13C, 1'b1);
      rx_frame(9'h13C, 1'b1, exp_len(8'd1, 1'b1), "R2 R3 9-bit x64 p1");
      idle_check("R7 idle after 9-bit frame");

      // R5 R6 R9: held strobe while full is ignored; next word follows at once
      period_val = 8'd0; div64_sel = 1'b0;
      wr_data = 9'h1C3; nine_bit_en = 1'b1; wr_stb = 1'b1;
      @(negedge clk);
      wr_data = 9'h0FF; nine_bit_en = 1'b0;          // ignored: buffer is full (R5)
      @(negedge clk);
      chk(shreg_empty == 1'b0, "R4 load of first word", shreg_empty, 0);
      chk(hold_empty == 1'b1, "R4 buffer drained", hold_empty, 1);
      wr_data = 9'h03C;                              // accepted now, buffered
      fork
         rx_frame(9'h1C3, 1'b1, 16, "R5 R9 first word intact");
         begin
            @(negedge clk);
            wr_stb = 1'b0;
            chk(hold_empty == 1'b0, "R6 second word buffered", hold_empty, 0);
            wr_data = 9'h1FF; nine_bit_en = 1'b1;    // R9: later input changes
            wr_stb = 1'b1;                           // R5: ignored while full
            @(negedge clk);
            wr_stb = 1'b0;
         end
      join
      chk(hold_empty == 1'b1, "R6 buffer drains at stop end", hold_empty, 1);
      rx_frame(9'h03C, 1'b0, 16, "R6 R9 back-to-back word");
      idle_check("R5 ignored word never sent");

      // R8 disable flushes frame and buffer
      period_val = 8'd2; div64_sel = 1'b0;
      launch(9'h055, 1'b0);
      wr_data = 9'h0AA; wr_stb = 1'b1;
      @(negedge clk);
      wr_stb = 1'b0;
      repeat (60) @(negedge clk);
      tx_en = 1'b0;
      @(negedge clk);
      chk(serial_out == 1'b1, "R8 line high when disabled", serial_out, 1);
      chk(hold_empty == 1'b1, "R8 buffer flushed", hold_empty, 1);
      chk(shreg_empty == 1'b1, "R8 frame aborted", shreg_empty, 1);
      wr_data = 9'h011; wr_stb = 1'b1;
      @(negedge clk);
      wr_stb = 1'b0;
      @(negedge clk);
      chk(hold_empty == 1'b1, "R8 write ignored while disabled", hold_empty, 1);
      tx_en = 1'b1;
      for (int c = 0; c < 200; c++) begin
         if (c % 50 == 0) idle_check("R8 nothing resumes after enable");
         @(negedge clk);
      end

      // randomized frames
      for (int k = 0; k < 8; k++) begin
         period_val = 8'($urandom % 4);
         div64_sel  = 1'($urandom % 2);
         d          = 9'($urandom);
         nine       = 1'($urandom % 2);
         blen       = exp_len(period_val, div64_sel);
         launch(d, nine);
         rx_frame(d, nine, blen, "R1 R2 R3 random frame");
         idle_check("R7 random idle");
      end

      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule